// File: doc/BRIEF.md
# Asynchronous Serial Transmit Framer

This block turns parallel bytes into asynchronous serial frames on one output line. A byte is handed over with a valid/ready handshake into a one-entry holding register. The shift engine moves it out when the engine is free. A frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period. Between frames the line rests high.

An 8-bit line-control input sets the frame format. It selects the word length, the stop length (one, one and a half, or two bit times), parity on or off, even or odd parity, and parity forced to a constant. One bit of the same input forces the line low as a break. Bit timing comes from an external one-cycle tick that marks one sixteenth of a bit time, so a half-bit stop period can be built. Two status outputs report when the holding register is free and when the whole transmitter is idle.

Top module: `sertx_framer`

## Requirements
- R1: Control bits [1:0] set the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits go out least significant bit first.
- R2: Control bit 2 clear gives a stop period of 16 ticks. Control bit 2 set gives 32 ticks, except with 5-bit words, where it gives 24 ticks. The stop period is high.
- R3: With control bit 3 set, one parity bit of 16 ticks follows the data bits. Control bit 4 set makes the count of ones in the data plus parity even. Control bit 4 clear makes that count odd. With control bit 3 clear, no parity bit is sent.
- R4: With control bits 3 and 5 both set, the parity bit is a constant: 1 when control bit 4 is clear and 0 when it is set.
- R5: While control bit 6 is set, the serial output is low at all times. It has no effect on framing progress or on the status outputs.
- R6: The idle line is high. Each frame starts with a low start bit of 16 ticks, and every start, data and parity bit lasts exactly 16 ticks. With a byte already waiting, the next start bit follows the stop period with no idle tick in between.
- R7: A byte is accepted on a clock edge where in_valid and in_ready are both high. in_ready and hold_empty are high exactly when the holding register is empty. After an acceptance, both are low until the shift engine takes the byte.
- R8: tx_empty is high exactly when the holding register is empty and no frame is in progress. After reset, tx_empty, hold_empty and in_ready are high and the line is high.
- R9: The format bits (control bits 0 to 5) are sampled when a frame starts. Changing them during a frame does not alter that frame.
- R10: Control bit 7 has no effect on the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse, one sixteenth of a bit time |
| ctrl | input | 8 | Line-control byte (format, break) |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send (unused upper bits ignored for short words) |
| in_ready | output | 1 | Holding register can take a byte |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register empty |
| tx_empty | output | 1 | Holding register and shift engine both idle |

## Verification
The assertions assume that tick pulses last one clock cycle, that ticks arrive while a frame is in progress, and that in_data stays stable while it is offered. The bench raises a tick every fourth cycle and offers bytes only in the cycle just after a tick. It changes the format bits only when it offers a new byte, which is always after the previous byte has left the holding register. Each byte's format is therefore known at the moment that byte starts its frame. The break bit is toggled on its own, at arbitrary cycles.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int WORD_MAX = 8;

    typedef struct packed {
        logic [1:0] len_sel;
        logic       stop_long;
        logic       par_on;
        logic       par_even;
        logic       par_stick;
    } fmt_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_t;

    function automatic fmt_t decode_fmt(input logic [7:0] c);
        fmt_t f;
        f.len_sel   = c[1:0];
        f.stop_long = c[2];
        f.par_on    = c[3];
        f.par_even  = c[4];
        f.par_stick = c[5];
        return f;
    endfunction

    function automatic logic [3:0] word_bits(input logic [1:0] sel);
        return 4'd5 + {2'b00, sel};
    endfunction

    function automatic logic parity_of(input fmt_t f, input logic [7:0] d);
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < WORD_MAX; i++) begin
            if (i < int'(word_bits(f.len_sel))) acc = acc ^ d[i];
        end
        if (f.par_stick) return ~f.par_even;
        return f.par_even ? acc : ~acc;
    endfunction

    function automatic int unsigned stop_ticks(input fmt_t f, input int unsigned tpb);
        if (!f.stop_long)        return tpb;
        if (f.len_sel == 2'b00)  return tpb + tpb / 2;
        return 2 * tpb;
    endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    input  logic       take,
    output logic       hold_full,
    output logic [7:0] hold_data
);

    assign in_ready = !hold_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (in_valid && in_ready) begin
            hold_full <= 1'b1;
            hold_data <= in_data;
        end else if (take) begin
            hold_full <= 1'b0;
        end
    end

    // R7: a held byte stays put until the shift engine takes it
    a_r7_hold_kept: assert property (@(posedge clk) disable iff (rst)
        (hold_full && !take) |=> (hold_full && $stable(hold_data)));

    // R7: an accepted byte fills the holding register
    a_r7_accept_fills: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> hold_full);

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  fmt_t       fmt_in,
    input  logic       hold_full,
    input  logic [7:0] hold_data,
    output logic       take,
    output logic       line,
    output logic       busy
);

    localparam int LIM_W = $clog2(2 * TICKS_PER_BIT + 1);
    localparam logic [LIM_W-1:0] BIT_LIM = LIM_W'(TICKS_PER_BIT);

    phase_t           ph;
    logic [LIM_W-1:0] tcnt;
    logic [LIM_W-1:0] stop_lim;
    logic [LIM_W-1:0] bit_lim;
    logic [2:0]       idx;
    logic [3:0]       nbits;
    logic [7:0]       sh;
    logic             par_q;
    logic             par_on_q;
    logic             bit_end;
    logic             last_data;

    assign take      = (ph == PH_IDLE) && hold_full;
    assign busy      = (ph != PH_IDLE);
    assign bit_lim   = (ph == PH_STOP) ? stop_lim : BIT_LIM;
    assign bit_end   = tick && (tcnt == bit_lim - 1'b1);
    assign last_data = ({1'b0, idx} == nbits - 4'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            tcnt     <= '0;
            stop_lim <= BIT_LIM;
            idx      <= '0;
            nbits    <= 4'd5;
            sh       <= '0;
            par_q    <= 1'b0;
            par_on_q <= 1'b0;
        end else if (ph == PH_IDLE) begin
            if (take) begin
                ph       <= PH_START;
                tcnt     <= '0;
                idx      <= '0;
                sh       <= hold_data;
                nbits    <= word_bits(fmt_in.len_sel);
                par_q    <= parity_of(fmt_in, hold_data);
                par_on_q <= fmt_in.par_on;
                stop_lim <= LIM_W'(stop_ticks(fmt_in, TICKS_PER_BIT));
            end
        end else if (tick) begin
            if (bit_end) begin
                tcnt <= '0;
                unique case (ph)
                    PH_START: ph <= PH_DATA;
                    PH_DATA: begin
                        sh  <= sh >> 1;
                        idx <= idx + 3'd1;
                        if (last_data) ph <= par_on_q ? PH_PAR : PH_STOP;
                    end
                    PH_PAR:  ph <= PH_STOP;
                    default: ph <= PH_IDLE;
                endcase
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (ph)
            PH_START: line = 1'b0;
            PH_DATA:  line = sh[0];
            PH_PAR:   line = par_q;
            default:  line = 1'b1;
        endcase
    end

    // R6: a frame in progress only advances on a tick
    a_r6_wait_for_tick: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> ($stable(ph) && $stable(tcnt)));

    // R1: the data index never runs past the sampled word length
    a_r1_index_bound: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_DATA) |-> ({1'b0, idx} < nbits));

    // R2: the stop period lasts no longer than two bit times
    a_r2_stop_bound: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_STOP) |-> (tcnt < LIM_W'(2 * TICKS_PER_BIT)));

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
    import sertx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [7:0] ctrl,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       txd,
    output logic       hold_empty,
    output logic       tx_empty
);

    logic       hold_full;
    logic [7:0] hold_data;
    logic       take;
    logic       line;
    logic       busy;
    fmt_t       fmt_now;

    assign fmt_now = decode_fmt(ctrl);

    sertx_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .take      (take),
        .hold_full (hold_full),
        .hold_data (hold_data)
    );

    sertx_shift #(
        .TICKS_PER_BIT (TICKS_PER_BIT)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .fmt_in    (fmt_now),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .take      (take),
        .line      (line),
        .busy      (busy)
    );

    assign txd        = ctrl[6] ? 1'b0 : line;
    assign hold_empty = !hold_full;
    assign tx_empty   = !hold_full && !busy;

    // R5: break holds the line low
    a_r5_break_low: assert property (@(posedge clk) disable iff (rst)
        ctrl[6] |-> !txd);

    // R8: an idle transmitter leaves the line high unless break is set
    a_r8_idle_high: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && !ctrl[6]) |-> txd);

    // R8: an empty transmitter implies an empty holding register
    a_r8_empty_hold: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> (hold_empty && in_ready));

endmodule

// File: tb/tb_sertx_framer.sv
module tb_sertx_framer;

    localparam int TPB      = 16;
    localparam int TICK_DIV = 4;
    localparam int N_DIR    = 12;
    localparam int N_RAND   = 90;
    localparam int WATCHDOG = 190000;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick;
    logic [7:0] ctrl;
    logic       in_valid;
    logic [7:0] in_data;
    logic       in_ready;
    logic       txd;
    logic       hold_empty;
    logic       tx_empty;

    int checks = 0;
    int fails  = 0;

    bit    q_lvl[$];
    string q_tag[$];

    always #4 clk = ~clk;

    sertx_framer #(.TICKS_PER_BIT(TPB)) dut (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .ctrl       (ctrl),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .txd        (txd),
        .hold_empty (hold_empty),
        .tx_empty   (tx_empty)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int bits_of(input logic [7:0] c);
        return 5 + int'(c[1:0]);
    endfunction

    function automatic bit par_of(input logic [7:0] d, input logic [7:0] c);
        bit acc;
        acc = 1'b0;
        for (int i = 0; i < bits_of(c); i++) acc = acc ^ d[i];
        if (c[5]) return ~c[4];
        return c[4] ? acc : ~acc;
    endfunction

    function automatic int stop_of(input logic [7:0] c);
        if (!c[2]) return TPB;
        if (c[1:0] == 2'b00) return TPB + TPB / 2;
        return 2 * TPB;
    endfunction

    task automatic push_bit(input bit lvl, input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            q_lvl.push_back(lvl);
            q_tag.push_back(tag);
        end
    endtask

    // Expected per-tick levels of one frame
    task automatic push_frame(input logic [7:0] d, input logic [7:0] c, input bit fmt_changed);
        string dtag;
        dtag = c[7] ? "R10" : (fmt_changed ? "R9" : "R1");
        push_bit(1'b0, TPB, "R6");
        for (int i = 0; i < bits_of(c); i++) push_bit(d[i], TPB, dtag);
        if (c[3]) push_bit(par_of(d, c), TPB, c[5] ? "R4" : "R3");
        push_bit(1'b1, stop_of(c), "R2");
    endtask

    function automatic logic [7:0] dir_ctrl(input int i);
        case (i)
            0:  return 8'h04;
            1:  return 8'h04;
            2:  return 8'h07;
            3:  return 8'h03;
            4:  return 8'h08;
            5:  return 8'h18;
            6:  return 8'h28;
            7:  return 8'h38;
            8:  return 8'h3B;
            9:  return 8'h83;
            10: return 8'h85;
            default: return 8'h0C;
        endcase
    endfunction

    initial begin
        int   cyc;
        int   sent;
        int   gap;
        int   settle;
        bit   brk_cur;
        bit   brk_next;
        bit   empty_prev;
        bit   bexp;
        bit   lvl;
        string tag;
        logic [7:0] fmt_byte;
        logic [7:0] fmt_prev;

        void'($urandom(32'd2024));
        rst      = 1'b1;
        tick     = 1'b0;
        ctrl     = 8'h03;
        in_valid = 1'b0;
        in_data  = 8'h00;
        fmt_byte = 8'h03;
        fmt_prev = 8'h03;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 reset txd", txd, 1'b1);
        check("R8 reset tx_empty", tx_empty, 1'b1);
        check("R7 reset hold_empty", hold_empty, 1'b1);
        check("R7 reset in_ready", in_ready, 1'b1);
        rst = 1'b0;

        cyc        = 0;
        sent       = 0;
        gap        = 0;
        settle     = 0;
        brk_cur    = 1'b0;
        empty_prev = 1'b1;

        while (sent < N_DIR + N_RAND || q_lvl.size() > 0 || settle < 40) begin
            @(negedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                check("watchdog", 1'b1, 1'b0);
                break;
            end

            // Line check on each tick (R5 break overrides, R6 idle high)
            if (cyc % TICK_DIV == 0) begin
                tick = 1'b1;
                if (q_lvl.size() > 0) begin
                    lvl = q_lvl.pop_front();
                    tag = q_tag.pop_front();
                end else begin
                    lvl = 1'b1;
                    tag = "R6";
                end
                if (brk_cur) check("R5 break", txd, 1'b0);
                else         check(tag, txd, lvl);
            end else begin
                tick = 1'b0;
            end

            // Acceptance happened on the edge just passed
            if (in_valid) begin
                in_valid = 1'b0;
                check("R7 hold_empty after accept", hold_empty, 1'b0);
                check("R7 in_ready after accept", in_ready, 1'b0);
                push_frame(in_data, fmt_byte, fmt_byte[5:0] != fmt_prev[5:0]);
                fmt_prev = fmt_byte;
                sent++;
                gap = (sent < N_DIR) ? 0 : int'($urandom_range(0, 3)) * int'($urandom_range(0, 120));
            end

            // R8: transmitter empty status
            bexp = (q_lvl.size() == 0) && empty_prev;
            check("R8 tx_empty", tx_empty, bexp);
            empty_prev = (q_lvl.size() == 0);

            if (gap > 0) gap--;

            // Offer a new byte right after a tick
            if (cyc % TICK_DIV == 1 && gap == 0 && in_ready && sent < N_DIR + N_RAND) begin
                if (sent < N_DIR) fmt_byte = dir_ctrl(sent);
                else              fmt_byte = {$urandom_range(0, 1) == 1, 1'b0, 6'($urandom())};
                in_data  = 8'($urandom());
                in_valid = 1'b1;
            end

            if (sent >= N_DIR + N_RAND && q_lvl.size() == 0 && !in_valid) settle++;

            brk_next = (cyc >= 2000 && cyc < 2300) || (cyc >= 40000 && cyc < 40090)
                       || (settle >= 10 && settle < 30);
            ctrl    = {fmt_byte[7], brk_next, fmt_byte[5:0]};
            brk_cur = brk_next;
        end

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule